// File: doc/BRIEF.md
# CAN Operating Mode Sequencer

This block holds the operating mode of a CAN controller: operation, reset, halt or sleep. A host selects a target mode through a two-bit request and a separate sleep bit. The block decides when that request may take effect. A request can take effect in the cycle it is seen, or it can wait for the current frame to finish. That choice depends on the node's role on the bus (transmitting, receiving or bus-off), on a four-way bus-off halt policy, and on whether a lock detector reports the bus stuck dominant.

The block also keeps the bus-off flag. The protocol engine signals entry to bus-off. The flag clears after a parameterised number of recessive-sequence events (128 by default), on a host recovery command, or whenever the controller is placed in reset mode. Error counting and bit timing stay in the protocol engine. Here they appear only as single-cycle status inputs.

Each mode change raises a one-clock done pulse, so software or a neighbouring block can wait for the change to complete without comparing mode codes.

Top module: `can_mode_seq`

## Requirements
- R1: After reset `cur_mode` reads 01 (reset mode), `in_busoff` is 0 and `mode_done` is 0. The mode codes are 00 operation, 01 reset, 10 halt and 11 sleep.
- R2: In operation mode a request of 11 (forced reset) gives reset mode at the next edge, whether the node is transmitting, receiving or bus-off.
- R3: In operation mode a request of 01 (reset) gives reset mode at the next edge unless `tx_active` is high and the node is not bus-off. While transmitting, the request waits until `frame_end` or `bus_idle` is seen.
- R4: In operation mode, outside bus-off, a request of 10 (halt) gives halt mode at the next edge when neither `tx_active` nor `rx_active` is high. Otherwise it waits until `frame_end` or `bus_idle` is seen.
- R5: A waiting reset or halt request completes at the next edge on `bus_err`, or on `arb_lost` while `tx_active` is high. An `arb_lost` seen without `tx_active` does not complete a waiting halt.
- R6: `bus_off_enter` in operation mode sets `in_busoff` at the next edge. The flag clears on the edge of the REC_LIMIT-th `rec11_evt` counted since entry (128 by default), on `recover_cmd`, or when the next mode is reset.
- R7: With halt policy 00, a halt request made during bus-off waits until `in_busoff` has cleared. With policy 11, the same request enters halt mode at the next edge.
- R8: With policy 01, halt mode is entered on the same edge that sets `in_busoff`. With policy 10, halt mode is entered on the edge that clears it. Both apply only when the request is 00 or 10.
- R9: While `bus_locked` is high, halt mode is never entered, whether by request or by policy. Reset requests are still honoured.
- R10: Sleep mode (11) is entered only from reset mode with request 01 or 11, or from halt mode with request 10, when `sleep_req` is 1. When `sleep_req` is 1 and the request names a different mode, the mode stays where it is.
- R11: In sleep mode, `sleep_req` = 0 returns the block to reset mode at the next edge. From reset or halt mode with `sleep_req` = 0, the block moves to the requested mode at the next edge, subject to R9.
- R12: `mode_done` is high for exactly the cycles in which `cur_mode` differs from its value one cycle earlier.
- R13: A waiting halt or reset completes at the first `frame_end` even when `tx_active` stays high because more frames are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_req | input | 2 | Requested mode: 00 operation, 01 reset, 10 halt, 11 forced reset |
| sleep_req | input | 1 | Sleep request bit |
| boff_policy | input | 2 | Bus-off halt policy |
| recover_cmd | input | 1 | Host command to end bus-off at once |
| tx_active | input | 1 | The node is transmitting |
| rx_active | input | 1 | The node is receiving |
| bus_idle | input | 1 | Bus idle seen this cycle |
| frame_end | input | 1 | Current frame finished this cycle |
| bus_err | input | 1 | Bus error seen this cycle |
| arb_lost | input | 1 | Arbitration lost this cycle |
| bus_off_enter | input | 1 | Error counters reached bus-off |
| rec11_evt | input | 1 | Sequence of 11 recessive bits seen |
| bus_locked | input | 1 | Bus held dominant |
| cur_mode | output | 2 | Current mode code |
| in_busoff | output | 1 | Bus-off state flag |
| mode_done | output | 1 | One-cycle pulse on every mode change |

## Verification
A wrong mode decision appears on `cur_mode` and `mode_done` at the edge that follows the triggering input. A request that completes too early or too late therefore shows up within one cycle. A bus-off recovery counter that is off by one does not show up until the boundary event count: the flag clears one edge early or one edge late, and under policy 10 the automatic halt slips by the same edge. A corrupted bus-off flag can stay hidden until a halt request or a policy-driven halt depends on it, so the bench compares all three outputs against its reference model on every cycle.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
   typedef enum logic [1:0] {
      MODE_OPER  = 2'b00,
      MODE_RESET = 2'b01,
      MODE_HALT  = 2'b10,
      MODE_SLEEP = 2'b11
   } can_mode_e;

   localparam logic [1:0] REQ_OPER  = 2'b00;
   localparam logic [1:0] REQ_RESET = 2'b01;
   localparam logic [1:0] REQ_HALT  = 2'b10;
   localparam logic [1:0] REQ_FORCE = 2'b11;

   localparam logic [1:0] POL_AFTER_RECOV = 2'b00;
   localparam logic [1:0] POL_AT_ENTRY    = 2'b01;
   localparam logic [1:0] POL_AT_EXIT     = 2'b10;
   localparam logic [1:0] POL_ON_REQUEST  = 2'b11;
endpackage

// File: rtl/can_busoff_track.sv
module can_busoff_track #(
   parameter int unsigned REC_LIMIT = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_oper,
   input  logic enter_evt,
   input  logic recover_cmd,
   input  logic rec_evt,
   input  logic clr,
   output logic busoff_o,
   output logic enter_o,
   output logic exit_o
);
   localparam int unsigned CW = (REC_LIMIT > 1) ? $clog2(REC_LIMIT) : 1;

   logic busoff_q;
   logic limit_hit;

   generate
      if (REC_LIMIT < 1) begin : g_bad_limit
         $error("can_busoff_track: REC_LIMIT must be at least 1");
      end
      if (REC_LIMIT == 1) begin : g_single
         assign limit_hit = rec_evt;
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(REC_LIMIT - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!busoff_q || clr || exit_o) begin
               cnt_q <= '0;
            end else if (rec_evt) begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
         assign limit_hit = rec_evt && (cnt_q == LAST);
      end
   endgenerate

   assign enter_o = enter_evt && in_oper && !busoff_q;
   assign exit_o  = busoff_q && (recover_cmd || limit_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busoff_q <= 1'b0;
      end else if (clr) begin
         busoff_q <= 1'b0;
      end else if (enter_o) begin
         busoff_q <= 1'b1;
      end else if (exit_o) begin
         busoff_q <= 1'b0;
      end
   end

   assign busoff_o = busoff_q;
endmodule

// File: rtl/can_mode_next.sv
module can_mode_next
   import can_mode_pkg::*;
(
   input  can_mode_e  mode_q,
   input  logic [1:0] mode_req,
   input  logic       sleep_req,
   input  logic [1:0] policy,
   input  logic       tx_active,
   input  logic       rx_active,
   input  logic       bus_idle,
   input  logic       frame_end,
   input  logic       bus_err,
   input  logic       arb_lost,
   input  logic       bus_locked,
   input  logic       busoff,
   input  logic       boff_rise,
   input  logic       boff_fall,
   output can_mode_e  mode_d
);
   logic halt_ok;
   logic frame_over;
   logic tx_role;
   logic auto_halt;
   logic asks_reset;

   always_comb begin
      halt_ok    = !bus_locked;
      frame_over = frame_end || bus_idle || bus_err || (tx_active && arb_lost);
      tx_role    = tx_active && !busoff;
      auto_halt  = ((policy == POL_AT_ENTRY) && boff_rise) ||
                   ((policy == POL_AT_EXIT)  && boff_fall);
      asks_reset = (mode_req == REQ_RESET) || (mode_req == REQ_FORCE);
      mode_d     = mode_q;
      case (mode_q)
         MODE_OPER: begin
            if (mode_req == REQ_FORCE) begin
               mode_d = MODE_RESET;
            end else if (mode_req == REQ_RESET) begin
               if (!tx_role || frame_over) mode_d = MODE_RESET;
            end else if (halt_ok && auto_halt) begin
               mode_d = MODE_HALT;
            end else if ((mode_req == REQ_HALT) && halt_ok) begin
               if (busoff) begin
                  if (policy == POL_ON_REQUEST) mode_d = MODE_HALT;
               end else if (!(tx_active || rx_active) || frame_over) begin
                  mode_d = MODE_HALT;
               end
            end
         end
         MODE_RESET: begin
            if (sleep_req) begin
               if (asks_reset) mode_d = MODE_SLEEP;
            end else if (mode_req == REQ_OPER) begin
               mode_d = MODE_OPER;
            end else if ((mode_req == REQ_HALT) && halt_ok) begin
               mode_d = MODE_HALT;
            end
         end
         MODE_HALT: begin
            if (sleep_req) begin
               if (mode_req == REQ_HALT) mode_d = MODE_SLEEP;
            end else if (mode_req == REQ_OPER) begin
               mode_d = MODE_OPER;
            end else if (asks_reset) begin
               mode_d = MODE_RESET;
            end
         end
         MODE_SLEEP: begin
            if (!sleep_req) mode_d = MODE_RESET;
         end
         default: mode_d = MODE_RESET;
      endcase
   end
endmodule

// File: rtl/can_mode_done.sv
module can_mode_done #(
   parameter int unsigned       W       = 2,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] mode_i,
   output logic         pulse_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= mode_i;
   end

   assign pulse_o = (prev_q != mode_i);
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
   import can_mode_pkg::*;
#(
   parameter int unsigned REC_LIMIT = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_req,
   input  logic       sleep_req,
   input  logic [1:0] boff_policy,
   input  logic       recover_cmd,
   input  logic       tx_active,
   input  logic       rx_active,
   input  logic       bus_idle,
   input  logic       frame_end,
   input  logic       bus_err,
   input  logic       arb_lost,
   input  logic       bus_off_enter,
   input  logic       rec11_evt,
   input  logic       bus_locked,
   output logic [1:0] cur_mode,
   output logic       in_busoff,
   output logic       mode_done
);
   can_mode_e mode_q;
   can_mode_e mode_d;
   logic      boff_rise;
   logic      boff_fall;
   logic      boff_q;

   can_busoff_track #(.REC_LIMIT(REC_LIMIT)) u_boff (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_oper    (mode_q == MODE_OPER),
      .enter_evt  (bus_off_enter),
      .recover_cmd(recover_cmd),
      .rec_evt    (rec11_evt),
      .clr        (mode_d == MODE_RESET),
      .busoff_o   (boff_q),
      .enter_o    (boff_rise),
      .exit_o     (boff_fall)
   );

   can_mode_next u_next (
      .mode_q    (mode_q),
      .mode_req  (mode_req),
      .sleep_req (sleep_req),
      .policy    (boff_policy),
      .tx_active (tx_active),
      .rx_active (rx_active),
      .bus_idle  (bus_idle),
      .frame_end (frame_end),
      .bus_err   (bus_err),
      .arb_lost  (arb_lost),
      .bus_locked(bus_locked),
      .busoff    (boff_q),
      .boff_rise (boff_rise),
      .boff_fall (boff_fall),
      .mode_d    (mode_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_RESET;
      else        mode_q <= mode_d;
   end

   can_mode_done #(.W(2), .RST_VAL(MODE_RESET)) u_done (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode_q),
      .pulse_o(mode_done)
   );

   assign cur_mode  = mode_q;
   assign in_busoff = boff_q;
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_req,
   input logic       sleep_req,
   input logic       tx_active,
   input logic       recover_cmd,
   input logic       bus_locked,
   input logic [1:0] cur_mode,
   input logic       in_busoff,
   input logic       mode_done
);
   assert_force_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'b00 && mode_req == 2'b11) |=> (cur_mode == 2'b01));

   assert_reset_not_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'b00 && mode_req == 2'b01 && !tx_active) |=> (cur_mode == 2'b01));

   assert_recover_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_busoff && recover_cmd) |=> !in_busoff);

   assert_no_halt_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode != 2'b10 && bus_locked) |=> (cur_mode != 2'b10));

   assert_no_sleep_from_oper_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'b00) |=> (cur_mode != 2'b11));

   assert_wake_to_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'b11 && !sleep_req) |=> (cur_mode == 2'b01));

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mode_done == (cur_mode != $past(cur_mode)));
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_req   (mode_req),
   .sleep_req  (sleep_req),
   .tx_active  (tx_active),
   .recover_cmd(recover_cmd),
   .bus_locked (bus_locked),
   .cur_mode   (cur_mode),
   .in_busoff  (in_busoff),
   .mode_done  (mode_done)
);

// File: tb/can_mode_seq_bench.sv
module can_mode_seq_bench;
   localparam int LIM = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_req = 2'b01;
   logic       sleep_req = 1'b0;
   logic [1:0] boff_policy = 2'b00;
   logic       recover_cmd = 1'b0;
   logic       tx_active = 1'b0;
   logic       rx_active = 1'b0;
   logic       bus_idle = 1'b0;
   logic       frame_end = 1'b0;
   logic       bus_err = 1'b0;
   logic       arb_lost = 1'b0;
   logic       bus_off_enter = 1'b0;
   logic       rec11_evt = 1'b0;
   logic       bus_locked = 1'b0;
   logic [1:0] cur_mode;
   logic       in_busoff;
   logic       mode_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   int e_mode;
   bit e_boff;
   int e_cnt;

   always #4 clk = ~clk;

   can_mode_seq u_can_mode_seq (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .sleep_req(sleep_req),
      .boff_policy(boff_policy), .recover_cmd(recover_cmd), .tx_active(tx_active),
      .rx_active(rx_active), .bus_idle(bus_idle), .frame_end(frame_end),
      .bus_err(bus_err), .arb_lost(arb_lost), .bus_off_enter(bus_off_enter),
      .rec11_evt(rec11_evt), .bus_locked(bus_locked), .cur_mode(cur_mode),
      .in_busoff(in_busoff), .mode_done(mode_done)
   );

   task automatic quiet();
      recover_cmd = 0; tx_active = 0; rx_active = 0; bus_idle = 0; frame_end = 0;
      bus_err = 0; arb_lost = 0; bus_off_enter = 0; rec11_evt = 0; bus_locked = 0;
   endtask

   // Reference model: one clock of the mode rules, then compare at the falling edge.
   task automatic step(input string tag);
      int  nm;
      bit  nb;
      int  nc;
      bit  entering, leaving, ends, may_halt, busy;
      nm = e_mode; nb = e_boff; nc = e_cnt;
      entering = bus_off_enter && (e_mode == 0) && !e_boff;
      leaving  = e_boff && (recover_cmd || (rec11_evt && (e_cnt == LIM - 1)));
      ends     = frame_end || bus_idle || bus_err || (tx_active && arb_lost);
      may_halt = !bus_locked;
      busy     = tx_active || rx_active;
      if (e_mode == 0) begin
         if (mode_req == 3) nm = 1;
         else if (mode_req == 1) nm = (tx_active && !e_boff && !ends) ? 0 : 1;
         else if (may_halt && ((boff_policy == 1 && entering) || (boff_policy == 2 && leaving))) nm = 2;
         else if (mode_req == 2 && may_halt) begin
            if (e_boff) nm = (boff_policy == 3) ? 2 : 0;
            else if (!busy || ends) nm = 2;
         end
      end else if (e_mode == 1) begin
         if (sleep_req) nm = (mode_req == 1 || mode_req == 3) ? 3 : 1;
         else if (mode_req == 0) nm = 0;
         else if (mode_req == 2 && may_halt) nm = 2;
      end else if (e_mode == 2) begin
         if (sleep_req) nm = (mode_req == 2) ? 3 : 2;
         else if (mode_req == 0) nm = 0;
         else if (mode_req != 2) nm = 1;
      end else begin
         if (!sleep_req) nm = 1;
      end
      if (e_boff) begin
         if (leaving) begin nb = 0; nc = 0; end
         else if (rec11_evt) nc = e_cnt + 1;
      end
      if (entering) begin nb = 1; nc = 0; end
      if (nm == 1) begin nb = 0; nc = 0; end
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (cur_mode !== nm[1:0] || in_busoff !== nb || mode_done !== (nm != e_mode)) begin
         errors++;
         $display("FAIL %s: mode=%0d busoff=%0b done=%0b expected mode=%0d busoff=%0b done=%0b",
                  tag, cur_mode, in_busoff, mode_done, nm, nb, (nm != e_mode));
      end
      e_mode = nm; e_boff = nb; e_cnt = nc;
   endtask

   task automatic steps(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      e_mode = 1; e_boff = 0; e_cnt = 0;
      // R1: reset state
      checks++;
      if (cur_mode !== 2'b01 || in_busoff !== 1'b0 || mode_done !== 1'b0) begin
         errors++;
         $display("FAIL R1: mode=%0d busoff=%0b done=%0b expected mode=1 busoff=0 done=0",
                  cur_mode, in_busoff, mode_done);
      end
      steps("R1", 2);
      // R11, R12: reset -> operation
      mode_req = 2'b00; step("R11"); step("R12");
      // R3: reset waits for a transmission
      tx_active = 1; mode_req = 2'b01; steps("R3", 3);
      frame_end = 1; step("R3"); frame_end = 0; quiet();
      mode_req = 2'b00; step("R11");
      // R2: forced reset while transmitting
      tx_active = 1; mode_req = 2'b11; step("R2"); quiet();
      mode_req = 2'b00; step("R11");
      // R3: reset while receiving is immediate
      rx_active = 1; mode_req = 2'b01; step("R3"); quiet();
      mode_req = 2'b00; step("R11");
      // R4: halt waits for a reception, ends on bus idle
      rx_active = 1; mode_req = 2'b10; steps("R4", 2);
      bus_idle = 1; step("R4"); quiet();
      mode_req = 2'b00; step("R11");
      mode_req = 2'b10; step("R4");
      mode_req = 2'b00; step("R11");
      // R13: queued transmissions, tx_active stays high
      tx_active = 1; mode_req = 2'b10; steps("R13", 2);
      frame_end = 1; step("R13"); frame_end = 0; step("R13"); quiet();
      mode_req = 2'b00; step("R11");
      // R5: aborts
      tx_active = 1; mode_req = 2'b01; step("R5"); arb_lost = 1; step("R5"); quiet();
      mode_req = 2'b00; step("R11");
      tx_active = 1; mode_req = 2'b10; step("R5"); bus_err = 1; step("R5"); quiet();
      mode_req = 2'b00; step("R11");
      rx_active = 1; mode_req = 2'b10; arb_lost = 1; steps("R5", 2);
      arb_lost = 0; bus_err = 1; step("R5"); quiet();
      mode_req = 2'b00; step("R11");
      // R9: locked bus blocks halt, not reset
      bus_locked = 1; mode_req = 2'b10; steps("R9", 3);
      mode_req = 2'b01; step("R9");
      mode_req = 2'b10; steps("R9", 2);
      bus_locked = 0; step("R9");
      mode_req = 2'b00; step("R11");
      // R6: bus-off with the recessive-sequence limit
      boff_policy = 2'b00;
      bus_off_enter = 1; step("R6"); bus_off_enter = 0;
      rec11_evt = 1; steps("R6", LIM - 1); step("R6"); rec11_evt = 0; step("R6");
      bus_off_enter = 1; step("R6"); bus_off_enter = 0;
      recover_cmd = 1; step("R6"); recover_cmd = 0;
      bus_off_enter = 1; step("R6"); bus_off_enter = 0;
      mode_req = 2'b11; step("R6");
      mode_req = 2'b00; step("R11");
      // R7: policy 00 waits, policy 11 immediate
      bus_off_enter = 1; step("R7"); bus_off_enter = 0;
      mode_req = 2'b10; steps("R7", 3);
      recover_cmd = 1; step("R7"); recover_cmd = 0; step("R7");
      mode_req = 2'b00; step("R11");
      boff_policy = 2'b11;
      bus_off_enter = 1; step("R7"); bus_off_enter = 0;
      mode_req = 2'b10; step("R7");
      mode_req = 2'b11; step("R7");
      mode_req = 2'b00; step("R11");
      // R8: automatic halt at entry and at exit
      boff_policy = 2'b01;
      bus_off_enter = 1; step("R8"); bus_off_enter = 0;
      mode_req = 2'b01; step("R8");
      mode_req = 2'b00; step("R11");
      bus_locked = 1; bus_off_enter = 1; step("R9"); bus_off_enter = 0; bus_locked = 0;
      recover_cmd = 1; step("R8"); recover_cmd = 0;
      boff_policy = 2'b10;
      bus_off_enter = 1; step("R8"); bus_off_enter = 0; steps("R8", 2);
      rec11_evt = 1; steps("R8", LIM); rec11_evt = 0; step("R8");
      // R10, R11: sleep from halt and reset
      mode_req = 2'b10; sleep_req = 1; step("R10");
      sleep_req = 0; step("R11");
      mode_req = 2'b11; step("R11");
      mode_req = 2'b00; sleep_req = 1; steps("R10", 3);
      mode_req = 2'b10; steps("R10", 2);
      mode_req = 2'b01; step("R10"); steps("R10", 2);
      sleep_req = 0; step("R11");
      mode_req = 2'b10; step("R11");
      mode_req = 2'b00; sleep_req = 1; steps("R10", 2);
      sleep_req = 0; step("R11");
      quiet();
      steps("R12", 2);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not end, actual=timeout expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule